// File: doc/BRIEF.md
# Minimal 16-bit-instruction CPU core

A small single-issue processor core. Each cycle it presents its program counter on an instruction-fetch port, takes one fixed 16-bit instruction back, decodes the 4-bit opcode in the top bits, and executes it against sixteen 8-bit general registers. Every instruction finishes in one cycle except a load, which waits for the data memory to signal valid data.

Register 0 is the program counter itself. Reading it gives the address of the instruction being executed. Writing it with any result redirects fetch, so jumps, calls and returns are ordinary register writes. A call saves a return address in R15 with an add-immediate on R0, then loads R0. A return is an ADD that places R15 plus a zero register into R0.

The data port reaches RAM in the lower half of the address space and IO in the upper half. A write to the first IO address updates an LED output register held in the core. A synchronous reset release stage sits in front of the whole core.

Top module: `cpu16_core`

## Requirements
- R1: While reset is active and until its synchronized release, `instr_addr` is 0, both strobes are low and `led` is 0. Registers R1..R15 come out of reset holding 0.
- R2: The program counter advances by one after each completed instruction, unless that instruction writes R0 or is a load still waiting for data.
- R3: Instruction layout is opcode [15:12], DEST [11:8], OP1 [7:4] and OP2 [3:0]. Opcodes 1 to 5 write R[OP1] op R[OP2] into R[DEST], where the operation is ADD, SUB, AND, OR or XOR in that order. All results are modulo 256.
- R4: Opcode 6 (INV) writes ~R[OP1] into R[DEST]. Opcode A writes R[OP1] shifted left by one, with a zero fill. Opcode B writes R[OP1] shifted right by one, with a zero fill. Opcode C (ADDI) writes R[OP1] + OP2, with OP2 taken as a 4-bit unsigned value.
- R5: Opcode 7 (LDI) writes the 8-bit immediate {OP1,OP2} into R[DEST].
- R6: Opcode 0 (NOP) and the reserved opcodes D, E and F write no register and raise no strobe. The program counter still advances.
- R7: Reading R0 yields the address of the executing instruction. Writing R0 makes the written value the next fetch address, with no increment, so call and return work through R15.
- R8: Opcode 9 (STORE) raises `mem_we` for one cycle. The address is R[OP1] + OP2 (4-bit unsigned offset, modulo 256) and the data is R[DEST].
- R9: Opcode 8 (LOAD) raises `mem_re` at the same effective address as a store. The instruction, address and strobe hold until `mem_rvalid` is high. In that cycle `mem_rdata` is written into R[DEST].
- R10: `led` takes `mem_wdata` at the clock edge that ends a write to address 0x80. A write to any other address leaves `led` unchanged.
- R11: `mem_re` and `mem_we` are never high together. When neither is high, `mem_addr` and `mem_wdata` are driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_addr | output | 8 | Fetch address (program counter) |
| instr_data | input | 16 | Instruction at `instr_addr`, combinational from the ROM |
| mem_addr | output | 8 | Data address; bit 7 set selects IO |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Load data, sampled when `mem_rvalid` is high |
| mem_re | output | 1 | Load request |
| mem_we | output | 1 | Store strobe |
| mem_rvalid | input | 1 | Load data valid |
| led | output | 8 | LED output register at IO address 0x80 |

## Verification
The bench builds the core with its default 8-bit data width, sixteen registers and LED address 0x80. With these values every ALU operation can be swept over all 64 pairs of eight edge values (0x00, 0x01, 0x0F, 0x7F, 0x80, 0xAA, 0xFE, 0xFF). Each result is stored to RAM and compared against sums, differences and bit operations computed in the bench. The 8-bit address space is small enough for programs that call a function, wrap the effective address past 0xFF and hit both the LED address and its neighbour. The same load program runs with memory latencies of 0, 1 and 3 cycles, so the exact stall length of each load is counted.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0,
    OP_ADD  = 4'h1,
    OP_SUB  = 4'h2,
    OP_AND  = 4'h3,
    OP_OR   = 4'h4,
    OP_XOR  = 4'h5,
    OP_INV  = 4'h6,
    OP_LDI  = 4'h7,
    OP_LOAD = 4'h8,
    OP_STOR = 4'h9,
    OP_SHL  = 4'hA,
    OP_SHR  = 4'hB,
    OP_ADDI = 4'hC,
    OP_RSVD = 4'hF
  } opcode_e;

  localparam int INSTR_W = 16;
  localparam int FIELD_W = 4;

  function automatic logic writes_reg(input opcode_e op);
    return op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_INV,
                      OP_LDI, OP_LOAD, OP_SHL, OP_SHR, OP_ADDI};
  endfunction

endpackage

// File: rtl/cpu16_rst_sync.sv
module cpu16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [cpu16_pkg::FIELD_W-1:0] wr_idx,
  input  logic [DW-1:0]              wr_val,
  input  logic [cpu16_pkg::FIELD_W-1:0] rd_a_idx,
  input  logic [cpu16_pkg::FIELD_W-1:0] rd_b_idx,
  input  logic [cpu16_pkg::FIELD_W-1:0] rd_c_idx,
  input  logic [DW-1:0]              pc_val,
  output logic [DW-1:0]              rd_a,
  output logic [DW-1:0]              rd_b,
  output logic [DW-1:0]              rd_c
);
  localparam int FW = cpu16_pkg::FIELD_W;

  // Entry 0 of the architectural file is the program counter, held outside.
  logic [DW-1:0] gpr_q [1:NREG-1];

  for (genvar gi = 1; gi < NREG; gi++) begin : g_gpr
    logic ld_en;
    assign ld_en = wr_en && (wr_idx == FW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     gpr_q[gi] <= '0;
      else if (ld_en) gpr_q[gi] <= wr_val;
    end
  end

  function automatic logic [DW-1:0] rd_port(input logic [FW-1:0] idx,
                                            input logic [DW-1:0] pcv);
    logic [DW-1:0] v;
    v = pcv;
    for (int k = 1; k < NREG; k++) begin
      if (idx == FW'(k)) v = gpr_q[k];
    end
    return v;
  endfunction

  always_comb begin
    rd_a = rd_port(rd_a_idx, pc_val);
    rd_b = rd_port(rd_b_idx, pc_val);
    rd_c = rd_port(rd_c_idx, pc_val);
  end
endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu #(
  parameter int DW = 8
) (
  input  cpu16_pkg::opcode_e op,
  input  logic [DW-1:0]      a,
  input  logic [DW-1:0]      b,
  input  logic [7:0]         imm8,
  input  logic [3:0]         imm4,
  output logic [DW-1:0]      y
);
  import cpu16_pkg::*;

  always_comb begin
    y = '0;
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_INV:  y = ~a;
      OP_LDI:  y = DW'(imm8);
      OP_SHL:  y = {a[DW-2:0], 1'b0};
      OP_SHR:  y = {1'b0, a[DW-1:1]};
      OP_ADDI: y = a + DW'(imm4);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core #(
  parameter int            DW       = 8,
  parameter int            NREG     = 16,
  parameter int            SYNC_STG = 2,
  parameter logic [DW-1:0] LED_ADDR = {1'b1, {(DW-1){1'b0}}}
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] instr_addr,
  input  logic [15:0]   instr_data,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_re,
  output logic          mem_we,
  input  logic          mem_rvalid,
  output logic [DW-1:0] led
);
  import cpu16_pkg::*;
  localparam int FW = FIELD_W;

  logic core_rst_n;

  cpu16_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (core_rst_n)
  );

  opcode_e       op;
  logic [FW-1:0] f_dst, f_op1, f_op2;
  assign op    = opcode_e'(instr_data[15:12]);
  assign f_dst = instr_data[11:8];
  assign f_op1 = instr_data[7:4];
  assign f_op2 = instr_data[3:0];

  logic [DW-1:0] pc_q, pc_nxt;
  logic          pc_en;
  logic [DW-1:0] led_q, led_nxt;
  logic          led_en;

  logic [DW-1:0] rd_a, rd_b, rd_c, alu_y, eff_addr, wr_val;
  logic          wr_en, ld_wait;

  cpu16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .wr_en    (wr_en),
    .wr_idx   (f_dst),
    .wr_val   (wr_val),
    .rd_a_idx (f_op1),
    .rd_b_idx (f_op2),
    .rd_c_idx (f_dst),
    .pc_val   (pc_q),
    .rd_a     (rd_a),
    .rd_b     (rd_b),
    .rd_c     (rd_c)
  );

  cpu16_alu #(.DW(DW)) u_alu (
    .op   (op),
    .a    (rd_a),
    .b    (rd_b),
    .imm8 ({f_op1, f_op2}),
    .imm4 (f_op2),
    .y    (alu_y)
  );

  assign eff_addr = rd_a + DW'(f_op2);

  // Decode and bus drive: defaults request nothing.
  always_comb begin
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    wr_en     = 1'b0;
    wr_val    = alu_y;
    ld_wait   = 1'b0;
    if (core_rst_n) begin
      case (op)
        OP_LOAD: begin
          mem_re   = 1'b1;
          mem_addr = eff_addr;
          ld_wait  = !mem_rvalid;
          wr_en    = mem_rvalid;
          wr_val   = mem_rdata;
        end
        OP_STOR: begin
          mem_we    = 1'b1;
          mem_addr  = eff_addr;
          mem_wdata = rd_c;
        end
        default: wr_en = writes_reg(op);
      endcase
    end
  end

  // Next-state for PC and LED register.
  always_comb begin
    pc_en   = core_rst_n && !ld_wait;
    pc_nxt  = (wr_en && f_dst == '0) ? wr_val : pc_q + 1'b1;
    led_en  = mem_we && (mem_addr == LED_ADDR);
    led_nxt = mem_wdata;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q  <= '0;
      led_q <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_nxt;
      if (led_en) led_q <= led_nxt;
    end
  end

  assign instr_addr = pc_q;
  assign led        = led_q;
endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk #(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] LED_ADDR = {1'b1, {(DW-1){1'b0}}}
) (
  input logic          clk,
  input logic          ext_rst_n,
  input logic          run_n,
  input logic [DW-1:0] instr_addr,
  input logic [15:0]   instr_data,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_re,
  input logic          mem_we,
  input logic          mem_rvalid,
  input logic [DW-1:0] led
);
  import cpu16_pkg::*;

  opcode_e       op;
  logic          hits_pc, waiting;
  logic [DW-1:0] pc_inc;
  assign op      = opcode_e'(instr_data[15:12]);
  assign hits_pc = writes_reg(op) && instr_data[11:8] == 4'h0;
  assign waiting = mem_re && !mem_rvalid;
  assign pc_inc  = instr_addr + 1'b1;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !ext_rst_n |-> (!mem_re && !mem_we && instr_addr == '0 && led == '0)); // R1

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!run_n)
    (!waiting && !hits_pc) |=> instr_addr == $past(pc_inc)); // R2

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!run_n)
    (op == OP_NOP || instr_data[15:12] >= 4'hD) |-> (!mem_re && !mem_we)); // R6

  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!run_n)
    waiting |=> (mem_re && $stable(mem_addr) && $stable(instr_addr))); // R9

  AST_LED_SET: assert property (@(posedge clk) disable iff (!run_n)
    (mem_we && mem_addr == LED_ADDR) |=> led == $past(mem_wdata)); // R10

  AST_LED_KEEP: assert property (@(posedge clk) disable iff (!run_n)
    !(mem_we && mem_addr == LED_ADDR) |=> $stable(led)); // R10

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!run_n)
    !(mem_re && mem_we)); // R11

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!run_n)
    (!mem_re && !mem_we) |-> (mem_addr == '0 && mem_wdata == '0)); // R11
endmodule

bind cpu16_core cpu16_core_chk #(.DW(DW), .LED_ADDR(LED_ADDR)) u_chk (
  .clk        (clk),
  .ext_rst_n  (rst_n),
  .run_n      (core_rst_n),
  .instr_addr (instr_addr),
  .instr_data (instr_data),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_re     (mem_re),
  .mem_we     (mem_we),
  .mem_rvalid (mem_rvalid),
  .led        (led)
);

// File: tb/cpu16_core_tb.sv
`timescale 1ns/1ps
module cpu16_core_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  instr_addr, mem_addr, mem_wdata, mem_rdata, led;
  logic [15:0] instr_data;
  logic        mem_re, mem_we, mem_rvalid;

  always #5 clk = ~clk;

  cpu16_core u_dut (
    .clk(clk), .rst_n(rst_n), .instr_addr(instr_addr), .instr_data(instr_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_re(mem_re), .mem_we(mem_we), .mem_rvalid(mem_rvalid), .led(led)
  );

  // ROM, RAM and latency model
  logic [15:0] rom [256];
  logic [7:0]  ram [128];
  int          lat, lat_cnt;

  assign instr_data = rom[instr_addr];
  assign mem_rdata  = ram[mem_addr[6:0]];
  assign mem_rvalid = mem_re && (lat_cnt == lat);

  always @(posedge clk) begin
    if (mem_we && !mem_addr[7]) ram[mem_addr[6:0]] <= mem_wdata;
    if (mem_re && !mem_rvalid) lat_cnt <= lat_cnt + 1;
    else                       lat_cnt <= 0;
  end

  int checks = 0, errors = 0;
  int pb, n_exp, n_seen, re_cycles, idle_bad;
  logic  mon_en = 1'b0;
  logic [7:0] exp_a [256];
  logic [7:0] exp_d [256];
  string      exp_r [256];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (mem_re) re_cycles++;
      if (!mem_re && !mem_we && (mem_addr != 8'h0 || mem_wdata != 8'h0)) idle_bad++;
      if (mem_we) begin
        if (n_seen < n_exp) begin
          chk(mem_addr == exp_a[n_seen], {exp_r[n_seen], " addr"}, mem_addr, exp_a[n_seen]);
          chk(mem_wdata == exp_d[n_seen], {exp_r[n_seen], " data"}, mem_wdata, exp_d[n_seen]);
        end else begin
          chk(1'b0, "R2 extra store", mem_addr, 0);
        end
        n_seen++;
      end
    end
  end

  function automatic logic [15:0] enc(input logic [3:0] o, d, a, b);
    return {o, d, a, b};
  endfunction

  task automatic emit(input logic [15:0] w);
    rom[pb] = w;
    pb++;
  endtask

  task automatic expect_st(input logic [7:0] a, input logic [7:0] d, input string r);
    exp_a[n_exp] = a; exp_d[n_exp] = d; exp_r[n_exp] = r;
    n_exp++;
  endtask

  task automatic new_prog();
    for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
    pb = 0; n_exp = 0;
  endtask

  task automatic halt();
    logic [7:0] h;
    h = 8'(pb);
    emit(enc(4'h7, 4'h0, h[7:4], h[3:0]));
  endtask

  task automatic run_prog(input int cycles, input int latency);
    rst_n = 1'b0; mon_en = 1'b0;
    lat = latency;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_seen = 0; re_cycles = 0; idle_bad = 0;
    mon_en = 1'b1;
    repeat (cycles) @(negedge clk);
    mon_en = 1'b0;
    chk(n_seen == n_exp, "R2 store count", n_seen, n_exp);
    chk(idle_bad == 0, "R11 idle bus", idle_bad, 0);
  endtask

  function automatic logic [7:0] alu_ref(input int k, input logic [7:0] a, b);
    case (k)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return ~a;
      6: return {a[6:0], 1'b0};
      7: return {1'b0, a[7:1]};
      default: return a + {4'h0, b[3:0]};
    endcase
  endfunction

  localparam logic [3:0] OPS [9] = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB, 4'hC};
  localparam logic [7:0] VALS [8] = '{8'h00, 8'h01, 8'h0F, 8'h7F, 8'h80, 8'hAA, 8'hFE, 8'hFF};

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    lat = 0;
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(instr_addr == 8'h0, "R1 pc in reset", instr_addr, 0);
    chk(!mem_re && !mem_we, "R1 strobes in reset", {mem_re, mem_we}, 0);
    chk(led == 8'h0, "R1 led in reset", led, 0);

    // R3 R4 R5: ALU sweep, ten operand pairs per program
    for (int base = 0; base < 64; base += 10) begin
      new_prog();
      for (int v = base; v < base + 10 && v < 64; v++) begin
        logic [7:0] a, b;
        a = VALS[v / 8]; b = VALS[v % 8];
        emit(enc(4'h7, 4'h1, a[7:4], a[3:0]));
        emit(enc(4'h7, 4'h2, b[7:4], b[3:0]));
        for (int k = 0; k < 9; k++) begin
          if (k == 8) emit(enc(OPS[k], 4'h3, 4'h1, b[3:0]));
          else        emit(enc(OPS[k], 4'h3, 4'h1, 4'h2));
          emit(enc(4'h9, 4'h3, 4'h4, 4'(k)));
          expect_st(8'(k), alu_ref(k, a, b), (k < 5) ? "R3 alu" : "R4 alu");
        end
        emit(enc(4'h9, 4'h2, 4'h4, 4'h9));
        expect_st(8'h09, b, "R5 ldi");
      end
      halt();
      run_prog(pb + 8, 0);
    end

    // R6: NOP and reserved opcodes; R1: untouched register reads 0
    new_prog();
    emit(enc(4'h7, 4'h5, 4'h3, 4'hC));
    emit(16'h0000);
    emit(enc(4'hD, 4'h5, 4'h1, 4'h2));
    emit(enc(4'hE, 4'h5, 4'h5, 4'h5));
    emit(enc(4'hF, 4'h5, 4'h0, 4'h0));
    emit(enc(4'h9, 4'h5, 4'h4, 4'h0)); expect_st(8'h00, 8'h3C, "R6 reserved no write");
    emit(enc(4'h9, 4'h7, 4'h4, 4'h1)); expect_st(8'h01, 8'h00, "R1 reg reset value");
    halt();
    run_prog(20, 0);

    // R7 R8: call, return, reading R0, address offset and wrap
    new_prog();
    rom[0]  = enc(4'h7, 4'hD, 4'h0, 4'h0);
    rom[1]  = enc(4'hC, 4'hF, 4'h0, 4'h4);   // R15 = 1 + 4
    rom[2]  = enc(4'h7, 4'h0, 4'h1, 4'h0);   // jump to 16
    rom[3]  = enc(4'h7, 4'h6, 4'hE, 4'hE);
    rom[4]  = enc(4'h7, 4'h6, 4'hE, 4'hE);
    rom[5]  = enc(4'h9, 4'h6, 4'h4, 4'h1);
    rom[6]  = enc(4'h9, 4'h0, 4'h4, 4'h2);
    rom[7]  = enc(4'h7, 4'h4, 4'h2, 4'h0);
    rom[8]  = enc(4'h9, 4'h6, 4'h4, 4'hF);
    rom[9]  = enc(4'h7, 4'h4, 4'hF, 4'h8);
    rom[10] = enc(4'h9, 4'h6, 4'h4, 4'hF);
    rom[11] = enc(4'h7, 4'h0, 4'h0, 4'hB);   // halt
    rom[16] = enc(4'h7, 4'h6, 4'h1, 4'h1);
    rom[17] = enc(4'h9, 4'h6, 4'h4, 4'h0);
    rom[18] = enc(4'h1, 4'h0, 4'hF, 4'hD);   // return
    expect_st(8'h00, 8'h11, "R7 call target");
    expect_st(8'h01, 8'h11, "R7 return skips");
    expect_st(8'h02, 8'h06, "R7 read R0");
    expect_st(8'h2F, 8'h11, "R8 offset");
    expect_st(8'h07, 8'h11, "R8 address wrap");
    run_prog(30, 0);

    // R9: loads at three latencies
    for (int li = 0; li < 3; li++) begin
      int lv;
      lv = (li == 2) ? 3 : li;
      new_prog();
      emit(enc(4'h7, 4'h1, 4'h5, 4'hA));
      emit(enc(4'h9, 4'h1, 4'h4, 4'h3)); expect_st(8'h03, 8'h5A, "R8 store");
      emit(enc(4'h7, 4'h1, 4'hC, 4'h3));
      emit(enc(4'h7, 4'h4, 4'h1, 4'h0));
      emit(enc(4'h9, 4'h1, 4'h4, 4'h4)); expect_st(8'h14, 8'hC3, "R8 store");
      emit(enc(4'h8, 4'h8, 4'h4, 4'h4));
      emit(enc(4'h7, 4'h4, 4'h0, 4'h0));
      emit(enc(4'h8, 4'h9, 4'h4, 4'h3));
      emit(enc(4'h9, 4'h8, 4'h4, 4'h5)); expect_st(8'h05, 8'hC3, "R9 load data");
      emit(enc(4'h9, 4'h9, 4'h4, 4'h6)); expect_st(8'h06, 8'h5A, "R9 load data");
      halt();
      run_prog(40, lv);
      chk(re_cycles == 2 * (lv + 1), "R9 stall length", re_cycles, 2 * (lv + 1));
    end

    // R10: LED write and neighbours; R1: reset clears led
    new_prog();
    emit(enc(4'h7, 4'h1, 4'h8, 4'h1));
    emit(enc(4'h7, 4'h4, 4'h8, 4'h0));
    emit(enc(4'h9, 4'h1, 4'h4, 4'h0)); expect_st(8'h80, 8'h81, "R10 led write");
    emit(enc(4'h7, 4'h2, 4'h4, 4'h2));
    emit(enc(4'h9, 4'h2, 4'h4, 4'h1)); expect_st(8'h81, 8'h42, "R10 io neighbour");
    emit(enc(4'h7, 4'h4, 4'h0, 4'h0));
    emit(enc(4'h9, 4'h2, 4'h4, 4'h0)); expect_st(8'h00, 8'h42, "R10 ram write");
    halt();
    run_prog(20, 0);
    chk(led == 8'h81, "R10 led holds", led, 8'h81);
    rst_n = 1'b0;
    @(negedge clk);
    chk(led == 8'h00, "R1 led cleared", led, 0);
    chk(instr_addr == 8'h00, "R1 pc cleared", instr_addr, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule